// File: doc/BRIEF.md
# Galois LFSR Period Counter

This block counts clock ticks with an 11-bit Galois linear-feedback shift register instead of a binary counter. It serves as the coarse stage of a clock divider. Software or a neighbouring block loads a start value. That value is an LFSR state, not a binary count. The register then advances one step on every enabled tick until it reaches the all-ones terminal state.

On the tick taken at the terminal state, the block raises a one-tick terminal pulse. On that same tick it reloads the programmed start state, so the pulse repeats with a fixed period. The period in ticks is one more than the number of steps from the loaded state to the terminal state. A count of n is therefore programmed by loading the state that sits n-1 steps before all-ones in the sequence.

The all-zero state lies outside the sequence. Loading it parks the counter: it does not move and no pulse appears. The block does not convert binary counts to LFSR states; whoever programs it must do that.

Top module: `lfsr_period_counter`

## Requirements
- R1: After synchronous reset, state_o is 0 and term_o is low.
- R2: When load_i is high at a clock edge, state_o equals start_i from the next cycle, and that value becomes the programmed reload state.
- R3: When tick_i is high, load_i is low and state_o is neither 0 nor 0x7FF, the next state is state_o >> 1 if bit 0 is clear, and (state_o >> 1) XOR 0x500 if bit 0 is set.
- R4: When tick_i and load_i are both low, state_o holds its value.
- R5: term_o is high in exactly those cycles where tick_i is high, load_i is low and state_o is 0x7FF. At that edge the state returns to the programmed reload state.
- R6: A loaded state that is d steps before 0x7FF in the sequence gives term_o pulses every d+1 ticks. This holds across the whole range, from 2 ticks (the state one step before 0x7FF) to 2047 ticks (the state one step after 0x7FF).
- R7: While state_o is 0, ticks do not change the state and term_o stays low.
- R8: load_i takes priority over tick_i. In a cycle with load_i high, term_o is low and the state takes start_i, even at the terminal state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Strobe that programs and loads start_i |
| start_i | input | 11 | LFSR start state to program |
| tick_i | input | 1 | Count enable; one step per high cycle |
| term_o | output | 1 | Terminal pulse, high for one tick |
| state_o | output | 11 | Current LFSR state |

## Verification
Periods of 2, 3, 100 and 2047 ticks are loaded and run under continuous ticking. This separates an off-by-one in the reload from an error in the recurrence, and the two range ends expose a wrong terminal comparison. A gapped tick pattern separates stepping on the clock from stepping on the enable. A reload issued at the terminal state separates load priority from wrap. A zero load separates the parked state from ordinary counting. A reference model steps the stated recurrence and compares every cycle.

// File: rtl/lfsr_cnt_pkg.sv
package lfsr_cnt_pkg;

    localparam int unsigned LFSR_W = 11;
    localparam logic [LFSR_W-1:0] FB_MASK = 11'h500;

    typedef logic [LFSR_W-1:0] lstate_t;

    localparam lstate_t TERM_STATE = '1;
    localparam lstate_t PARK_STATE = '0;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_LOAD,
        ACT_STEP,
        ACT_WRAP
    } act_e;

    typedef struct packed {
        lstate_t reload;
        lstate_t cur;
    } cnt_regs_t;

endpackage

// File: rtl/lfsr_next.sv
module lfsr_next #(
    parameter int unsigned W = lfsr_cnt_pkg::LFSR_W,
    parameter logic [W-1:0] FB = lfsr_cnt_pkg::FB_MASK
) (
    input  logic [W-1:0] cur_i,
    output logic [W-1:0] nxt_o
);
    logic [W:0] ext;
    assign ext = {1'b0, cur_i};

    for (genvar b = 0; b < W; b++) begin : g_bit
        if (FB[b]) begin : g_tap
            assign nxt_o[b] = ext[b+1] ^ cur_i[0];
        end else begin : g_plain
            assign nxt_o[b] = ext[b+1];
        end
    end
endmodule

// File: rtl/lfsr_action.sv
module lfsr_action #(
    parameter int unsigned W = lfsr_cnt_pkg::LFSR_W
) (
    input  logic                load_i,
    input  logic                tick_i,
    input  logic [W-1:0]        cur_i,
    output lfsr_cnt_pkg::act_e  act_o,
    output logic                term_o
);
    import lfsr_cnt_pkg::*;

    logic at_term;
    logic parked;

    assign at_term = &cur_i;
    assign parked  = ~|cur_i;

    always_comb begin
        if (load_i)
            act_o = ACT_LOAD;
        else if (tick_i && !parked)
            act_o = at_term ? ACT_WRAP : ACT_STEP;
        else
            act_o = ACT_HOLD;
    end

    assign term_o = (act_o == ACT_WRAP);
endmodule

// File: rtl/lfsr_period_counter.sv
module lfsr_period_counter #(
    parameter int unsigned W = lfsr_cnt_pkg::LFSR_W,
    parameter logic [W-1:0] FB = lfsr_cnt_pkg::FB_MASK
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] start_i,
    input  logic         tick_i,
    output logic         term_o,
    output logic [W-1:0] state_o
);
    import lfsr_cnt_pkg::*;

    logic [W-1:0] cur_q;
    logic [W-1:0] reload_q;
    logic [W-1:0] stepped;
    act_e         act;

    lfsr_next #(.W(W), .FB(FB)) u_next (
        .cur_i (cur_q),
        .nxt_o (stepped)
    );

    lfsr_action #(.W(W)) u_act (
        .load_i (load_i),
        .tick_i (tick_i),
        .cur_i  (cur_q),
        .act_o  (act),
        .term_o (term_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q    <= '0;
            reload_q <= '0;
        end else begin
            unique case (act)
                ACT_LOAD: begin
                    cur_q    <= start_i;
                    reload_q <= start_i;
                end
                ACT_STEP: cur_q <= stepped;
                ACT_WRAP: cur_q <= reload_q;
                default:  cur_q <= cur_q;
            endcase
        end
    end

    assign state_o = cur_q;
endmodule

// File: rtl/lfsr_period_counter_chk.sv
module lfsr_period_counter_chk #(
    parameter int unsigned W = 11,
    parameter logic [W-1:0] FB = 11'h500
) (
    input logic         clk,
    input logic         rst,
    input logic         load_i,
    input logic [W-1:0] start_i,
    input logic         tick_i,
    input logic         term_o,
    input logic [W-1:0] state_o
);
    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (state_o == $past(start_i)));

    assert_step_R3: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !load_i && state_o != '0 && state_o != '1) |=>
        (state_o == (($past(state_o) >> 1) ^ ($past(state_o[0]) ? FB : '0))));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !load_i) |=> $stable(state_o));

    assert_term_R5: assert property (@(posedge clk) disable iff (rst)
        term_o |-> (tick_i && state_o == '1));

    assert_park_R7: assert property (@(posedge clk) disable iff (rst)
        (state_o == '0 && !load_i) |=> (state_o == '0));

    assert_prio_R8: assert property (@(posedge clk) disable iff (rst)
        load_i |-> !term_o);
endmodule

bind lfsr_period_counter lfsr_period_counter_chk #(.W(W), .FB(FB)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load_i),
    .start_i (start_i),
    .tick_i  (tick_i),
    .term_o  (term_o),
    .state_o (state_o)
);

// File: tb/lfsr_period_counter_tb.sv
module lfsr_period_counter_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_i = 1'b0;
    logic [10:0] start_i = '0;
    logic        tick_i = 1'b0;
    logic        term_o;
    logic [10:0] state_o;

    int checks = 0;
    int failures = 0;
    int m_state = 0;
    int m_start = 0;
    int seq [0:2046];

    always #5 clk = ~clk;

    lfsr_period_counter u_dut (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load_i),
        .start_i (start_i),
        .tick_i  (tick_i),
        .term_o  (term_o),
        .state_o (state_o)
    );

    function automatic int nxt(int s);
        return (s & 1) ? ((s >> 1) ^ 'h500) : (s >> 1);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic ld, input int st, input logic tk,
                       input string tag, output logic seen);
        logic exp_term;
        @(negedge clk);
        load_i = ld; start_i = st[10:0]; tick_i = tk;
        #1;
        exp_term = tk && !ld && (m_state == 'h7FF);
        check(int'(state_o) == m_state, {tag, " state"}, state_o, m_state);
        check(term_o == exp_term, {tag, " term"}, term_o, exp_term);
        seen = term_o;
        if (ld) begin
            m_start = st; m_state = st;
        end else if (tk && m_state != 0) begin
            m_state = (m_state == 'h7FF) ? m_start : nxt(m_state);
        end
    endtask

    // R6: a state d steps before 0x7FF repeats every d+1 ticks
    task automatic run_period(input int n);
        logic seen;
        int cnt;
        cyc(1'b1, seq[(2048 - n) % 2047], 1'b0, "R2", seen);
        for (int p = 0; p < 2; p++) begin
            cnt = 0;
            seen = 1'b0;
            while (!seen && cnt < 2100) begin
                cyc(1'b0, 0, 1'b1, "R3", seen);
                cnt++;
            end
            check(cnt == n, "R6 period", cnt, n);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic seen;
        int tc;
        seq[0] = 'h7FF;
        for (int k = 1; k < 2047; k++) seq[k] = nxt(seq[k-1]);

        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        check(state_o == 11'h0, "R1 reset state", state_o, 0);
        check(term_o == 1'b0, "R1 reset term", term_o, 0);

        // R6 at both range ends and between
        run_period(2);
        run_period(3);
        run_period(100);
        run_period(2047);

        // R4: gapped ticks, period 5 must still count only ticks
        cyc(1'b1, seq[2043], 1'b0, "R2", seen);
        tc = 0;
        for (int i = 0; i < 40; i++) begin
            cyc(1'b0, 0, i[0], "R4", seen);
            if (i[0]) tc++;
            if (seen) begin
                check(tc == 5, "R6 gapped period", tc, 5);
                tc = 0;
            end
        end

        // R2: reload in the middle of a count
        cyc(1'b1, seq[1000], 1'b0, "R2", seen);
        for (int i = 0; i < 7; i++) cyc(1'b0, 0, 1'b1, "R3", seen);
        cyc(1'b1, seq[2040], 1'b1, "R2 mid-count", seen);
        check(int'(state_o) == seq[1007], "R2 pre-load state", state_o, seq[1007]);

        // R8: load at terminal state with tick
        cyc(1'b1, 'h7FF, 1'b0, "R2", seen);
        cyc(1'b1, seq[2045], 1'b1, "R8", seen);
        check(seen == 1'b0, "R8 no term on load", seen, 0);
        @(negedge clk); #1;
        check(int'(state_o) == seq[2045], "R8 load wins", state_o, seq[2045]);
        for (int i = 0; i < 9; i++) cyc(1'b0, 0, 1'b1, "R5", seen);

        // R7: parked zero state
        cyc(1'b1, 0, 1'b0, "R2", seen);
        tc = 0;
        for (int i = 0; i < 50; i++) begin
            cyc(1'b0, 0, 1'b1, "R7", seen);
            if (seen) tc++;
        end
        check(tc == 0, "R7 no term while parked", tc, 0);
        @(negedge clk); #1;
        check(state_o == 11'h0, "R7 parked state", state_o, 0);

        // R1 again: reset during counting
        cyc(1'b1, seq[5], 1'b0, "R2", seen);
        @(negedge clk); rst = 1'b1; load_i = 1'b0; tick_i = 1'b1;
        @(negedge clk); rst = 1'b0; tick_i = 1'b0; #1;
        check(state_o == 11'h0, "R1 reset mid-count", state_o, 0);
        m_state = 0; m_start = 0;
        cyc(1'b0, 0, 1'b1, "R7", seen);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule